// File: doc/BRIEF.md
# Serial EEPROM Boot Image Reader

This block pulls a boot image out of a serial EEPROM over a two-wire bus as soon as reset is released. It acts as the only master on the bus. It drives the clock line directly. The data line is open drain, so it is modelled as a pull-low enable output (`sdaOe`) and a sensed input (`sdaIn`). The bus clock period is `CLK_DIV` system clocks. In the intended system that is 256, which makes the bus clock equal to the audio sample rate.

The access pattern is fixed. A start condition is followed by the device address with the write flag, and then a 16-bit memory pointer of zero. A repeated start and the device address with the read flag come next. After that, `IMAGE_BYTES` bytes are streamed in one sequential read. The master acknowledges every received byte except the last one, which it leaves unacknowledged before it issues a stop. Each received byte appears on `dataOut` with a one-cycle `dataValid` pulse. The block then raises `done` and leaves both lines idle until the next reset. If the slave fails to acknowledge any of the four preamble bytes, the reader sets `bootErr` and closes the transfer with a stop.

Top module: `eeprom_boot_reader`

## Requirements
- R1: After reset is released, the first bus event is a start condition: the data line is pulled low while the clock line is high, before any data bit is clocked.
- R2: The first byte sent after the start is 0xA0, transmitted MSB first. Its upper nibble is 1010, the three select bits are 000 and the final read/write bit is 0 (write).
- R3: The next two bytes sent are the memory pointer 0x00 then 0x00. The top three bits of the high pointer byte are always zero.
- R4: After the pointer bytes, a repeated start is issued and the byte 0xA1 (the same address with the read/write bit set to 1) is sent. Exactly two start conditions occur in a complete boot.
- R5: Every clock high phase and low phase between the first full bit and the stop lasts exactly `CLK_DIV/2` system clocks. The data line changes while the clock line is high only to form a start or a stop.
- R6: Exactly `IMAGE_BYTES` bytes are delivered, in memory order. Each is assembled MSB first from the bus and presented on `dataOut` during a single-cycle `dataValid` pulse.
- R7: In the ninth clock of each received byte, the master pulls the data line low (ACK) for every byte except the last. For the last byte it releases the line (NACK), and this is followed by exactly one stop condition.
- R8: After the stop, `done` goes high and stays high. The clock line then stays high and `sdaOe` stays low until the next reset.
- R9: If the data line is high (no slave ACK) in the ninth clock of any of the four preamble bytes, `bootErr` goes high, a stop is issued, `done` goes high, and no `dataValid` pulse is produced.
- R10: The data line is never driven high; a 1 is produced by releasing `sdaOe`. While reset is asserted, `sclOut`=1, `sdaOe`=0, and `dataValid`, `done` and `bootErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; the boot sequence starts when it is released |
| sdaIn | input | 1 | Sensed level of the data line |
| sclOut | output | 1 | Bus clock line |
| sdaOe | output | 1 | Pull-low enable for the data line (1 = drive low) |
| dataOut | output | 8 | Received image byte |
| dataValid | output | 1 | One-cycle strobe marking a new byte on dataOut |
| done | output | 1 | Boot transfer finished, interface locked |
| bootErr | output | 1 | A preamble byte was not acknowledged |

## Verification
Two things fall on the same slot boundary: the acknowledge decision for the read-address byte and the switch into the receive phase. A missing ACK at that point must win and must keep the reader from clocking in any image data. The bench provokes this by having its behavioural slave withhold the ACK on exactly the fourth preamble byte, and on each of the other preamble bytes in separate runs. It then judges that `bootErr` rises, that no `dataValid` pulse appears, that the number of bytes seen on the bus stops at the refused one, and that a single stop ends the transfer. Normal runs use random images drawn from a seeded generator together with all-zero and all-one images. In those runs the bench checks every delivered byte and every master ACK/NACK against its own model of the EEPROM.

// File: rtl/boot_pkg.sv
package boot_pkg;

  // Kind of bus slot the control asks the datapath to produce
  typedef enum logic [1:0] {
    SLOT_IDLE,
    SLOT_START,
    SLOT_BIT,
    SLOT_STOP
  } slot_e;

  // Strobes from control to datapath, held constant for a whole slot
  typedef struct packed {
    slot_e kind;
    logic  bitOut;   // 1 = release line, 0 = pull low
    logic  shiftRx;  // capture the sampled bit into the receive register
  } slot_cmd_t;

  localparam logic [6:0]  DEV_ID     = 7'b1010_000;
  localparam logic [15:0] START_ADDR = 16'h0000;

endpackage

// File: rtl/boot_bus_dp.sv
module boot_bus_dp
  import boot_pkg::*;
#(
  parameter int CLK_DIV = 256
) (
  input  logic      clk,
  input  logic      rstN,
  input  slot_cmd_t cmd,
  input  logic      sdaIn,
  output logic      slotEnd,
  output logic      sclOut,
  output logic      sdaOe,
  output logic      sampled,
  output logic [7:0] rxByte
);

  localparam int QTR = CLK_DIV / 4;
  localparam int QW  = (QTR > 1) ? $clog2(QTR) : 1;

  logic [QW-1:0] qCnt;
  logic [1:0]    quarter;
  logic [1:0]    nextQ;
  logic          active;
  logic          qLast;
  logic          enterQ;
  logic          edgeKind;

  assign active   = (cmd.kind != SLOT_IDLE);
  assign qLast    = (qCnt == QW'(QTR - 1));
  assign enterQ   = active && qLast;
  assign nextQ    = quarter + 2'd1;
  assign slotEnd  = enterQ && (quarter == 2'd3);
  assign edgeKind = (cmd.kind == SLOT_START) || (cmd.kind == SLOT_STOP);

  // quarter-slot timer: q0,q1 clock low; q2,q3 clock high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qCnt    <= '0;
      quarter <= 2'd0;
    end else if (!active) begin
      qCnt    <= '0;
      quarter <= 2'd0;
    end else if (qLast) begin
      qCnt    <= '0;
      quarter <= nextQ;
    end else begin
      qCnt <= qCnt + 1'b1;
    end
  end

  // pin generation and sampling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOut  <= 1'b1;
      sdaOe   <= 1'b0;
      sampled <= 1'b1;
      rxByte  <= '0;
    end else if (!active) begin
      sclOut <= 1'b1;
      sdaOe  <= 1'b0;
    end else if (enterQ) begin
      sclOut <= nextQ[1] | ((cmd.kind == SLOT_STOP) & (nextQ == 2'd0));
      case (nextQ)
        2'd1: sdaOe <= (cmd.kind == SLOT_BIT) ? !cmd.bitOut : (cmd.kind == SLOT_STOP);
        2'd3: begin
          sampled <= sdaIn;
          if (cmd.kind == SLOT_START) sdaOe <= 1'b1;
          else if (cmd.kind == SLOT_STOP) sdaOe <= 1'b0;
          if ((cmd.kind == SLOT_BIT) && cmd.shiftRx) rxByte <= {rxByte[6:0], sdaIn};
        end
        default: ;
      endcase
    end
  end

  // R5
  sda_only_moves_when_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && $past(sclOut) && (sdaOe != $past(sdaOe))) |-> $past(edgeKind));

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_pkg::*;
#(
  parameter int IMAGE_BYTES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotEnd,
  input  logic       sampled,
  input  logic [7:0] rxByte,
  output slot_cmd_t  cmd,
  output logic [7:0] dataOut,
  output logic       dataValid,
  output logic       done,
  output logic       bootErr
);

  localparam int CW = (IMAGE_BYTES > 1) ? $clog2(IMAGE_BYTES) : 1;

  typedef enum logic [2:0] {ST_START, ST_TX, ST_RSTART, ST_RX, ST_STOP, ST_DONE} st_e;

  st_e           state;
  logic [7:0]    txShift;
  logic [3:0]    bitIdx;
  logic [1:0]    preIdx;
  logic [CW-1:0] rdCnt;
  logic          ackSlot;
  logic          lastByte;

  assign ackSlot  = (bitIdx == 4'd8);
  assign lastByte = (rdCnt == CW'(IMAGE_BYTES - 1));

  always_comb begin
    cmd = '{kind: SLOT_IDLE, bitOut: 1'b1, shiftRx: 1'b0};
    case (state)
      ST_START, ST_RSTART: cmd.kind = SLOT_START;
      ST_TX: begin
        cmd.kind   = SLOT_BIT;
        cmd.bitOut = ackSlot ? 1'b1 : txShift[7];
      end
      ST_RX: begin
        cmd.kind    = SLOT_BIT;
        cmd.bitOut  = ackSlot ? lastByte : 1'b1;
        cmd.shiftRx = !ackSlot;
      end
      ST_STOP: begin
        cmd.kind   = SLOT_STOP;
        cmd.bitOut = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_START;
      txShift   <= '0;
      bitIdx    <= '0;
      preIdx    <= '0;
      rdCnt     <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
      done      <= 1'b0;
      bootErr   <= 1'b0;
    end else begin
      dataValid <= 1'b0;
      if (slotEnd) begin
        case (state)
          ST_START: begin
            state   <= ST_TX;
            txShift <= {DEV_ID, 1'b0};
            bitIdx  <= '0;
            preIdx  <= 2'd0;
          end
          ST_RSTART: begin
            state   <= ST_TX;
            txShift <= {DEV_ID, 1'b1};
            bitIdx  <= '0;
            preIdx  <= 2'd3;
          end
          ST_TX: begin
            if (!ackSlot) begin
              txShift <= {txShift[6:0], 1'b0};
              bitIdx  <= bitIdx + 4'd1;
            end else if (sampled) begin
              bootErr <= 1'b1;
              state   <= ST_STOP;
            end else begin
              bitIdx <= '0;
              case (preIdx)
                2'd0: begin
                  txShift <= {3'b000, START_ADDR[12:8]};
                  preIdx  <= 2'd1;
                end
                2'd1: begin
                  txShift <= START_ADDR[7:0];
                  preIdx  <= 2'd2;
                end
                2'd2: state <= ST_RSTART;
                default: begin
                  state <= ST_RX;
                  rdCnt <= '0;
                end
              endcase
            end
          end
          ST_RX: begin
            if (!ackSlot) begin
              bitIdx <= bitIdx + 4'd1;
              if (bitIdx == 4'd7) begin
                dataOut   <= rxByte;
                dataValid <= 1'b1;
              end
            end else if (lastByte) begin
              state <= ST_STOP;
            end else begin
              bitIdx <= '0;
              rdCnt  <= rdCnt + 1'b1;
            end
          end
          ST_STOP: begin
            state <= ST_DONE;
            done  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R6
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(done) |-> done);

  // R9
  err_needs_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bootErr) |-> $past(sampled));

  // R9
  no_data_after_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    bootErr |-> !dataValid);

endmodule

// File: rtl/eeprom_boot_reader.sv
module eeprom_boot_reader
  import boot_pkg::*;
#(
  parameter int CLK_DIV     = 256,
  parameter int IMAGE_BYTES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaIn,
  output logic       sclOut,
  output logic       sdaOe,
  output logic [7:0] dataOut,
  output logic       dataValid,
  output logic       done,
  output logic       bootErr
);

  slot_cmd_t  cmd;
  logic       slotEnd;
  logic       sampled;
  logic [7:0] rxByte;

  boot_bus_dp #(.CLK_DIV(CLK_DIV)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .sdaIn  (sdaIn),
    .slotEnd(slotEnd),
    .sclOut (sclOut),
    .sdaOe  (sdaOe),
    .sampled(sampled),
    .rxByte (rxByte)
  );

  boot_seq_ctrl #(.IMAGE_BYTES(IMAGE_BYTES)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .slotEnd  (slotEnd),
    .sampled  (sampled),
    .rxByte   (rxByte),
    .cmd      (cmd),
    .dataOut  (dataOut),
    .dataValid(dataValid),
    .done     (done),
    .bootErr  (bootErr)
  );

  // R8
  locked_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> ($stable(sclOut) && $stable(sdaOe)));

endmodule

// File: tb/eeprom_boot_reader_tb_top.sv
`timescale 1ns/1ps
module eeprom_boot_reader_tb_top;

  localparam int DIV  = 16;
  localparam int NB   = 5;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic       scl, sdaOe, sdaIn, dataValid, done, bootErr;
  logic [7:0] dataOut;
  logic       slvPull;

  assign sdaIn = !(sdaOe || slvPull);

  eeprom_boot_reader #(.CLK_DIV(DIV), .IMAGE_BYTES(NB)) dut_i (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .sclOut(scl), .sdaOe(sdaOe),
    .dataOut(dataOut), .dataValid(dataValid), .done(done), .bootErr(bootErr)
  );

  int total = 0;
  int bad = 0;

  logic [7:0] img [NB];
  int nackPos;

  // bus monitor / slave model state
  logic       prevScl, prevSda, ackBit, lastAcked;
  bit         gotRise, readMode;
  int         bitCnt, wrIdx, rdAddr, seenCnt, ackCnt, starts, stops;
  int         validCnt, validBad, runLen, armSt, timingBad, runsChecked;
  logic [7:0] shiftIn;
  logic [7:0] seenBytes [8];
  logic       masterAck [NB];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      prevScl = 1'b1; prevSda = 1'b1; slvPull = 1'b0; gotRise = 0; readMode = 0;
      bitCnt = 0; wrIdx = 0; rdAddr = 0; seenCnt = 0; ackCnt = 0; starts = 0; stops = 0;
      validCnt = 0; validBad = 0; runLen = 0; armSt = 0; timingBad = 0; runsChecked = 0;
      shiftIn = '0; ackBit = 1'b1; lastAcked = 1'b0;
    end else begin
      if (dataValid) begin
        if (validCnt >= NB || dataOut !== img[validCnt]) validBad++;
        validCnt++;
      end
      if (scl !== prevScl) begin
        if (armSt == 2) begin
          runsChecked++;
          if (runLen != HALF) timingBad++;
        end
        if (armSt == 0 && !scl) armSt = 1;
        else if (armSt == 1 && scl) armSt = 2;
        runLen = 1;
      end else runLen++;

      if (prevScl && scl && prevSda && !sdaIn) begin
        starts++; gotRise = 0; bitCnt = 0;
      end else if (prevScl && scl && !prevSda && sdaIn) begin
        stops++;
      end else if (!prevScl && scl) begin
        gotRise = 1;
        if (bitCnt < 8) shiftIn = {shiftIn[6:0], sdaIn};
        else ackBit = sdaIn;
      end else if (prevScl && !scl && gotRise) begin
        gotRise = 0;
        if (bitCnt < 8) begin
          bitCnt++;
          if (bitCnt == 8) begin
            if (!readMode) begin
              if (seenCnt < 8) seenBytes[seenCnt] = shiftIn;
              seenCnt++;
              lastAcked = (wrIdx != nackPos);
              slvPull = lastAcked;
              wrIdx++;
            end else slvPull = 1'b0;
          end else if (readMode) slvPull = !img[rdAddr][7-bitCnt];
        end else begin
          bitCnt = 0;
          if (!readMode) begin
            slvPull = 1'b0;
            if (shiftIn == 8'hA1 && lastAcked) begin
              readMode = 1; rdAddr = 0; slvPull = !img[0][7];
            end
          end else begin
            if (ackCnt < NB) masterAck[ackCnt] = ackBit;
            ackCnt++;
            rdAddr++;
            if (!ackBit && rdAddr < NB) slvPull = !img[rdAddr][7];
            else slvPull = 1'b0;
          end
        end
      end
      prevScl = scl;
      prevSda = sdaIn;
    end
  end

  task automatic runOne(input int imgMode, input int nack);
    int waited;
    int lockBad;
    int startsAtDone, stopsAtDone;
    for (int i = 0; i < NB; i++) begin
      case (imgMode)
        1: img[i] = 8'h00;
        2: img[i] = 8'hFF;
        3: img[i] = (i % 2 == 0) ? 8'h80 : 8'h01;
        default: img[i] = 8'($urandom);
      endcase
    end
    nackPos = nack;
    @(negedge clk);
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(scl === 1'b1 && sdaOe === 1'b0 && dataValid === 1'b0 && done === 1'b0 && bootErr === 1'b0,
          "R10", "reset outputs {scl,oe,valid,done,err}",
          {scl, sdaOe, dataValid, done, bootErr}, 5'b10000);
    rstN = 1'b1;
    waited = 0;
    while (done !== 1'b1 && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(done === 1'b1, "R8", "watchdog: done reached", int'(done), 1);
    startsAtDone = starts; stopsAtDone = stops;
    lockBad = 0;
    repeat (4 * DIV) begin
      @(negedge clk);
      if (scl !== 1'b1 || sdaOe !== 1'b0 || done !== 1'b1 || dataValid !== 1'b0) lockBad++;
    end
    check(lockBad == 0 && starts == startsAtDone && stops == stopsAtDone, "R8",
          "bus idle and done held after stop", lockBad, 0);
    check(stops == 1, "R7", "stop count", stops, 1);
    check(seenCnt >= 1 && starts >= 1, "R1", "start before first byte", starts, 1);
    check(seenCnt >= 1 && seenBytes[0] == 8'hA0, "R2", "write address byte",
          int'(seenBytes[0]), 'hA0);
    check(timingBad == 0 && runsChecked > 4, "R5", "clock phase length errors", timingBad, 0);
    if (nack < 0) begin
      check(seenCnt == 4, "R3", "bytes sent by master", seenCnt, 4);
      check(seenBytes[1] == 8'h00 && seenBytes[2] == 8'h00, "R3", "pointer bytes",
            {seenBytes[1], seenBytes[2]}, 0);
      check(starts == 2 && seenBytes[3] == 8'hA1, "R4", "repeated start + read address",
            int'(seenBytes[3]) + 256 * starts, 'hA1 + 512);
      check(validCnt == NB && validBad == 0, "R6", "delivered byte count / mismatches",
            validCnt * 100 + validBad, NB * 100);
      check(ackCnt == NB, "R7", "acknowledge slots observed", ackCnt, NB);
      for (int i = 0; i < NB; i++)
        check(masterAck[i] == ((i == NB - 1) ? 1'b1 : 1'b0), "R7", "master ack level",
              int'(masterAck[i]), (i == NB - 1) ? 1 : 0);
      check(bootErr === 1'b0, "R9", "no error on clean boot", int'(bootErr), 0);
    end else begin
      check(bootErr === 1'b1, "R9", "error flag after refused byte", int'(bootErr), 1);
      check(validCnt == 0, "R9", "no data strobes after refusal", validCnt, 0);
      check(seenCnt == nack + 1, "R9", "bytes sent up to refusal", seenCnt, nack + 1);
      check(starts == ((nack == 3) ? 2 : 1), "R4", "start count on error path", starts,
            (nack == 3) ? 2 : 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    slvPull = 1'b0;
    runOne(0, -1);
    runOne(1, -1);
    runOne(2, -1);
    runOne(3, -1);
    runOne(0, -1);
    runOne(0, -1);
    runOne(0, 0);
    runOne(0, 1);
    runOne(0, 2);
    runOne(0, 3);
    runOne(0, -1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule